// File: doc/BRIEF.md
# SPI Target Shift Engine

This block is the byte-wide target (slave) side of an SPI link. The serial clock, data-in line and active-low select come from an external controller. All three pass through a synchronizer into the system clock domain, where clock transitions are detected as events. Because of this, the system clock must run at least four times faster than the serial clock.

Two configuration bits shape the link. One sets the level at which the serial clock rests when idle. The other chooses whether outgoing data changes when the clock leaves that idle level or when it returns to it. Incoming data is sampled on the opposite transition. Bytes travel most significant bit first.

Software loads the outgoing byte and requests enable. The engine arms only once the synchronized serial clock sits at the configured idle level. The live clock level is exported so software can watch for that condition. Each completed byte lands in a holding register and raises a buffer-full flag and a one-cycle done pulse. A byte that completes while the holding register is still unread sets an overflow flag instead.

Top module: `spi_target_engine`

## Requirements
- R1: `armed` becomes 1 only while `en_req` is 1 and the synchronized serial clock equals the idle level (`cfg_idle_high`=0 means idle low, 1 means idle high). While `en_req` is 0, `armed` is 0.
- R2: `sclk_level` reports the level of `sclk_in` no more than 3 system clocks after the pin changes.
- R3: With `cfg_launch_on_return`=1, received bits are sampled on idle-to-active transitions and `miso_out` advances on active-to-idle transitions.
- R4: With `cfg_launch_on_return`=0, received bits are sampled on active-to-idle transitions and `miso_out` advances on idle-to-active transitions. A launch transition advances `miso_out` only if a sample has occurred since the last advance or load, so bit 7 stays on the line through the first idle-to-active transition of a byte.
- R5: A pulse on `tx_load` captures `tx_byte`, and its bit 7 appears on `miso_out` one cycle later. Both directions move bit 7 first and bit 0 last.
- R6: After the 8th sample transition of a byte, `rx_byte` holds the received byte and `buf_full` is 1. `done` is 1 for exactly one cycle per completed byte.
- R7: A cycle with `rd_ack`=1 clears `buf_full` and `overflow`.
- R8: If a byte completes while `buf_full` is 1 and `rd_ack` is 0, `overflow` becomes 1 and `rx_byte` keeps the earlier byte.
- R9: While the synchronized `sel_n` is 1, `miso_oe` is 0 and the bit counter is reset, so bits received before a deselect are discarded.
- R10: Serial clock transitions while `armed` is 0 produce no `done` pulse and do not set `buf_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idle_high | input | 1 | Serial clock idle level: 0 means low, 1 means high |
| cfg_launch_on_return | input | 1 | 1: outgoing data changes on return to idle. 0: it changes on leaving idle |
| en_req | input | 1 | Enable request; takes effect once the clock is at idle |
| tx_load | input | 1 | One-cycle strobe that captures tx_byte |
| tx_byte | input | DATA_W | Byte to transmit |
| rd_ack | input | 1 | Read acknowledge; clears buf_full and overflow |
| sclk_in | input | 1 | External serial clock |
| sel_n | input | 1 | Active-low target select |
| mosi_in | input | 1 | Serial data from the controller |
| miso_out | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for miso_out |
| armed | output | 1 | Engine is enabled and accepting transitions |
| sclk_level | output | 1 | Synchronized live serial clock level |
| rx_byte | output | DATA_W | Holding register of the last accepted byte |
| buf_full | output | 1 | Holding register holds an unread byte |
| overflow | output | 1 | A byte was dropped because the holding register was full |
| done | output | 1 | One-cycle pulse when a byte completes |

## Verification
Suppose the bit counter is off by one, or the launch and sample roles are swapped. The fault then shows within the same byte: `rx_byte` comes out rotated or shifted, and the `miso_out` bits that the controller collects before each sample transition no longer match the loaded byte. If the arm gate is broken, `armed` rises within a few cycles of `en_req` even though the clock rests at the wrong level. A stale full or overflow state shows up at the next completed byte, as a wrong `rx_byte` or a flag that fails to clear after `rd_ack`. A deselect that does not reset the counter corrupts the first full byte sent after reselection.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  // Classified serial clock events in the system domain.
  typedef struct packed {
    logic launch;
    logic sample;
  } spi_evt_t;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
  import spi_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sclk_s,
  input  logic     idle_high,
  input  logic     launch_on_return,
  input  logic     en_req,
  output logic     armed,
  output logic     sclk_level,
  output spi_evt_t evt
);
  logic sclk_d;
  logic moved, leave_idle, back_idle;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign moved      = sclk_s ^ sclk_d;
  assign leave_idle = moved && (sclk_s != idle_high);
  assign back_idle  = moved && (sclk_s == idle_high);

  always_comb begin
    evt.launch = armed && (launch_on_return ? back_idle  : leave_idle);
    evt.sample = armed && (launch_on_return ? leave_idle : back_idle);
  end

  // Arm gate: enable request honoured only at the idle level.
  always_ff @(posedge clk) begin
    if (rst)                       armed <= 1'b0;
    else if (!en_req)              armed <= 1'b0;
    else if (sclk_s == idle_high)  armed <= 1'b1;
  end

  assign sclk_level = sclk_s;

  assert_arm_at_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> ($past(sclk_s) == $past(idle_high)) && $past(en_req));

  assert_arm_drop_R1: assert property (@(posedge clk) disable iff (rst)
    !en_req |=> !armed);

  // R3 / R4: one transition never both samples and launches
  assert_edges_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
    !(evt.launch && evt.sample));
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
  import spi_tgt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         armed,
  input  logic         sel_n_s,
  input  spi_evt_t     evt,
  input  logic         mosi_s,
  input  logic         tx_load,
  input  logic [W-1:0] tx_byte,
  input  logic         rd_ack,
  output logic         miso_out,
  output logic         miso_oe,
  output logic [W-1:0] rx_byte,
  output logic         buf_full,
  output logic         overflow,
  output logic         done
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     tx_sr, rx_sr;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             active;

  assign active = armed && !sel_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_byte  <= '0;
      cnt      <= '0;
      pend     <= 1'b0;
      buf_full <= 1'b0;
      overflow <= 1'b0;
      done     <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      done    <= 1'b0;
      miso_oe <= active;
      if (rd_ack) begin
        buf_full <= 1'b0;
        overflow <= 1'b0;
      end
      if (!active) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        if (evt.sample) begin
          rx_sr <= {rx_sr[W-2:0], mosi_s};
          pend  <= 1'b1;
          if (cnt == LAST) begin
            cnt  <= '0;
            done <= 1'b1;
            if (buf_full && !rd_ack) begin
              overflow <= 1'b1;
            end else begin
              rx_byte  <= {rx_sr[W-2:0], mosi_s};
              buf_full <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (evt.launch && pend) begin
          tx_sr <= {tx_sr[W-2:0], 1'b0};
          pend  <= 1'b0;
        end
      end
      if (tx_load) begin
        tx_sr <= tx_byte;
        pend  <= 1'b0;
      end
    end
  end

  assign miso_out = tx_sr[W-1];

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_keep_old_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $stable(rx_byte));

  assert_oe_off_R9: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !miso_oe);

  assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !done);
endmodule

// File: rtl/spi_target_engine.sv
module spi_target_engine
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_idle_high,
  input  logic              cfg_launch_on_return,
  input  logic              en_req,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rd_ack,
  input  logic              sclk_in,
  input  logic              sel_n,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              miso_oe,
  output logic              armed,
  output logic              sclk_level,
  output logic [DATA_W-1:0] rx_byte,
  output logic              buf_full,
  output logic              overflow,
  output logic              done
);
  localparam int unsigned STG = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic [2:0] pins_raw, pins_s;
  spi_evt_t   evt;

  assign pins_raw = {sel_n, mosi_in, sclk_in};

  spi_tgt_sync #(.W(3), .STAGES(STG), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  spi_tgt_edge u_edge (
    .clk              (clk),
    .rst              (rst),
    .sclk_s           (pins_s[0]),
    .idle_high        (cfg_idle_high),
    .launch_on_return (cfg_launch_on_return),
    .en_req           (en_req),
    .armed            (armed),
    .sclk_level       (sclk_level),
    .evt              (evt)
  );

  spi_tgt_shift #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .armed    (armed),
    .sel_n_s  (pins_s[2]),
    .evt      (evt),
    .mosi_s   (pins_s[1]),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .rd_ack   (rd_ack),
    .miso_out (miso_out),
    .miso_oe  (miso_oe),
    .rx_byte  (rx_byte),
    .buf_full (buf_full),
    .overflow (overflow),
    .done     (done)
  );
endmodule

// File: tb/tb_spi_target_engine.sv
module tb_spi_target_engine;
  localparam int H = 6;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_idle_high = 1'b0, cfg_launch_on_return = 1'b0, en_req = 1'b0;
  logic tx_load = 1'b0, rd_ack = 1'b0;
  logic [7:0] tx_byte = '0;
  logic sclk_in = 1'b0, sel_n = 1'b1, mosi_in = 1'b0;
  logic miso_out, miso_oe, armed, sclk_level, buf_full, overflow, done;
  logic [7:0] rx_byte;

  int errors = 0, checks = 0, done_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_target_engine dut (
    .clk(clk), .rst(rst), .cfg_idle_high(cfg_idle_high),
    .cfg_launch_on_return(cfg_launch_on_return), .en_req(en_req),
    .tx_load(tx_load), .tx_byte(tx_byte), .rd_ack(rd_ack),
    .sclk_in(sclk_in), .sel_n(sel_n), .mosi_in(mosi_in),
    .miso_out(miso_out), .miso_oe(miso_oe), .armed(armed),
    .sclk_level(sclk_level), .rx_byte(rx_byte), .buf_full(buf_full),
    .overflow(overflow), .done(done)
  );

  always @(posedge clk) if (!rst && done) done_cnt <= done_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic idle, input logic ret);
    en_req = 1'b0; cyc(2);
    cfg_idle_high = idle; cfg_launch_on_return = ret; sclk_in = idle;
    cyc(5);
    en_req = 1'b1; cyc(4);
  endtask

  task automatic load(input logic [7:0] b);
    tx_byte = b; tx_load = 1'b1; cyc(1); tx_load = 1'b0;
  endtask

  task automatic ack();
    rd_ack = 1'b1; cyc(1); rd_ack = 1'b0; cyc(1);
  endtask

  // Controller model: drives nbits bits MSB first, records miso before each sample.
  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] seen);
    logic idle, act;
    idle = cfg_idle_high; act = ~cfg_idle_high; seen = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi_in = mo[i];
      if (!cfg_launch_on_return) begin sclk_in = act; cyc(H); end
      else cyc(H);
      seen[i] = miso_out;
      if (!cfg_launch_on_return) sclk_in = idle; else sclk_in = act;
      cyc(H);
      if (cfg_launch_on_return) begin sclk_in = idle; cyc(H); end
    end
    cyc(4);
  endtask

  function automatic logic [7:0] rand_byte();
    return 8'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen, a, b;
    void'($urandom(32'd2024));
    cyc(3); rst = 1'b0; sel_n = 1'b0; cyc(4);

    chk(armed == 0, "R1 reset armed", armed, 0);
    chk(buf_full == 0 && overflow == 0, "R6 reset flags", {buf_full, overflow}, 0);
    chk(miso_oe == 0, "R9 reset oe", miso_oe, 0);

    // R1/R2: arm gating against the idle level
    cfg_idle_high = 1'b1; sclk_in = 1'b0; en_req = 1'b1; cyc(12);
    chk(armed == 0, "R1 held off at wrong level", armed, 0);
    chk(sclk_level == 0, "R2 level low", sclk_level, 0);
    sclk_in = 1'b1; cyc(3);
    chk(sclk_level == 1, "R2 level high", sclk_level, 1);
    cyc(2);
    chk(armed == 1, "R1 armed at idle", armed, 1);
    en_req = 1'b0; cyc(2);
    chk(armed == 0, "R1 disarm", armed, 0);

    // R10: clocking while disarmed
    cfg_launch_on_return = 1'b1; load(8'hA5); done_cnt = 0;
    xfer(8'h3C, 8, seen);
    chk(buf_full == 0 && done_cnt == 0, "R10 ignored while disarmed", {buf_full, done_cnt[3:0]}, 0);

    // R5: load shows MSB
    load(8'h80); chk(miso_out == 1, "R5 msb after load", miso_out, 1);
    load(8'h7F); chk(miso_out == 0, "R5 msb after load 0", miso_out, 0);

    // R3/R4/R5/R6/R7: random bytes in all modes
    for (int k = 0; k < 12; k++) begin
      logic [7:0] t, r;
      t = rand_byte(); r = rand_byte();
      if (k < 2) begin t = 8'h01; r = 8'h80; end
      configure(k[0], k[1]);
      load(t); done_cnt = 0;
      xfer(r, 8, seen);
      chk(seen == t, k[1] ? "R3 tx bits" : "R4 tx bits", seen, t);
      chk(rx_byte == r, k[1] ? "R3 rx byte" : "R4 rx byte", rx_byte, r);
      chk(buf_full == 1 && done_cnt == 1, "R6 full and single done", {buf_full, done_cnt[3:0]}, 5'h11);
      ack();
      chk(buf_full == 0, "R7 ack clears full", buf_full, 0);
    end

    // R8: overflow keeps old byte
    configure(1'b0, 1'b1);
    a = rand_byte(); b = ~a;
    load(8'h00); xfer(a, 8, seen);
    load(8'h00); xfer(b, 8, seen);
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    chk(rx_byte == a, "R8 old byte kept", rx_byte, a);
    ack();
    chk(overflow == 0 && buf_full == 0, "R7 ack clears overflow", {overflow, buf_full}, 0);

    // R9: deselect discards a partial byte
    configure(1'b1, 1'b0);
    load(8'hC3); done_cnt = 0;
    xfer(8'hF0, 4, seen);
    sel_n = 1'b1; cyc(4);
    chk(miso_oe == 0, "R9 oe off when deselected", miso_oe, 0);
    sel_n = 1'b0; cyc(4);
    chk(miso_oe == 1, "R9 oe on when selected", miso_oe, 1);
    load(8'h5A);
    xfer(8'h96, 8, seen);
    chk(rx_byte == 8'h96 && done_cnt == 1, "R9 clean byte after deselect", rx_byte, 8'h96);
    chk(seen == 8'h5A, "R4 tx after deselect", seen, 8'h5A);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule